// File: doc/BRIEF.md
# Multihit TDC Channel Hit Store

This block serves a single time-to-digital channel. While an event is being acquired, it watches edge-detected rising and falling strobes. Each strobe that the edge-select setting qualifies captures the current value of a free-running 16-bit timestamp into a stack whose depth is programmable. A 2-bit counter tracks every qualified hit modulo 4, including hits that arrive after the stack is full. A common strobe latches the reference time.

Readout begins with a start pulse. The stack is then popped newest first. Each stamp is turned into an interval against the common time: common minus hit in stop mode, or hit minus common in start mode. The interval is dropped if it exceeds the coarse full-scale limit or does not exceed the channel's sparse constant. Every surviving interval is presented on a valid/ready stream together with the hit count. A one-cycle done pulse closes the event and clears the store for the next one.

Top module: `tdc_hit_store`

## Requirements
- R1: `edge_sel_i` selects which strobes are captured: 2'b01 captures rising only, 2'b10 captures falling only, 2'b11 captures both, and 2'b00 captures none. A rising and a falling strobe in the same cycle count as one hit.
- R2: At most `depth_i` stamps are stored (1 to 16; 0 acts as 1, and values above 16 act as 16). Qualified hits beyond that depth are not stored.
- R3: Readout presents the stored stamps newest first.
- R4: The interval is `common - stamp` when `stop_mode_i`=1 and `stamp - common` when it is 0, computed modulo 2^16.
- R5: An interval greater than `full_scale_i * 16` is discarded.
- R6: Only intervals strictly greater than `sparse_i` are emitted.
- R7: `data_o[17:16]` and `hit_count_o` give the number of qualified hits in the event modulo 4, including hits that were not stored. The count reads 0 after done.
- R8: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `data_o` stays stable. `data_o[15:0]` is the interval.
- R9: `done_o` is high for exactly one cycle, after the last emitted word, and never together with `valid_o`. An event with no stored stamps raises done in the first readout cycle and emits no words.
- R10: After reset, `valid_o`=0, `done_o`=0, `hit_count_o`=0, and the store is empty.
- R11: Hit strobes during readout are neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ts_i | input | 16 | Free-running timestamp |
| rise_i | input | 1 | Rising-edge hit strobe |
| fall_i | input | 1 | Falling-edge hit strobe |
| common_i | input | 1 | Common reference strobe, latches ts_i |
| edge_sel_i | input | 2 | Edge selection |
| depth_i | input | 5 | Programmed store depth |
| stop_mode_i | input | 1 | 1 = common stop, 0 = common start |
| full_scale_i | input | 12 | Full-scale limit in units of 16 LSB |
| sparse_i | input | 16 | Per-channel sparse constant |
| read_start_i | input | 1 | Begin readout of the event |
| ready_i | input | 1 | Consumer ready |
| valid_o | output | 1 | Data word valid |
| data_o | output | 18 | {hit count, interval} |
| done_o | output | 1 | End of event readout |
| hit_count_o | output | 2 | Qualified hits modulo 4 |

## Verification
Faults are visible at the ports within the same readout. A stack pointer that is off by one shows up in the first emitted word as the wrong interval, or as a wrong number of words before done. A hit counter that is wrong or not cleared appears in the top bits of every word and in `hit_count_o` one cycle after done. A filter fault changes the word count for an event whose expected count is fixed in the vector table. A handshake fault shows as data changing while ready is held low.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int TS_W     = 16;
  localparam int DEPTH    = 16;
  localparam int FS_SHIFT = 4;
  localparam int FS_W     = TS_W - FS_SHIFT;
  localparam int HC_W     = 2;
  localparam int DEP_W    = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic {ST_ACQ, ST_READ} rd_state_e;
endpackage

// File: rtl/tdc_edge_qual.sv
module tdc_edge_qual (
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  // bit 0 enables rising, bit 1 enables falling; coincident strobes merge
  assign hit_o = (rise_i & sel_i[0]) | (fall_i & sel_i[1]);
endmodule

// File: rtl/tdc_lifo.sv
module tdc_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] limit_i,
  input  logic          pop_i,
  output logic [W-1:0]  top_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          push_ok;
  logic [IW-1:0] top_idx;

  assign push_ok = push_i && (cnt_q < limit_i);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign top_o   = (cnt_q != '0) ? mem_q[top_idx] : '0;
  assign count_o = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (push_ok && cnt_q == CW'(g))      mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (push_ok)                 cnt_q <= cnt_q + CW'(1);
    else if (pop_i && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/tdc_range_filter.sv
module tdc_range_filter #(
  parameter int TS_W     = 16,
  parameter int FS_SHIFT = 4,
  localparam int FS_W    = TS_W - FS_SHIFT
) (
  input  logic [TS_W-1:0] stamp_i,
  input  logic [TS_W-1:0] common_i,
  input  logic            stop_mode_i,
  input  logic [FS_W-1:0] full_scale_i,
  input  logic [TS_W-1:0] sparse_i,
  output logic [TS_W-1:0] diff_o,
  output logic            keep_o
);
  logic [TS_W-1:0] limit;

  assign diff_o = stop_mode_i ? (common_i - stamp_i) : (stamp_i - common_i);
  assign limit  = {full_scale_i, {FS_SHIFT{1'b0}}};
  assign keep_o = (diff_o <= limit) && (diff_o > sparse_i);
endmodule

// File: rtl/tdc_hit_store.sv
module tdc_hit_store
  import tdc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TS_W-1:0]     ts_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                common_i,
  input  logic [1:0]          edge_sel_i,
  input  logic [DEP_W-1:0]    depth_i,
  input  logic                stop_mode_i,
  input  logic [FS_W-1:0]     full_scale_i,
  input  logic [TS_W-1:0]     sparse_i,
  input  logic                read_start_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [HC_W+TS_W-1:0] data_o,
  output logic                done_o,
  output logic [HC_W-1:0]     hit_count_o
);
  rd_state_e        state_q;
  logic [TS_W-1:0]  common_q;
  logic [HC_W-1:0]  total_q;
  logic             hit_raw, acq, push, pop, clear;
  logic [DEP_W-1:0] depth_eff, count;
  logic [TS_W-1:0]  top, diff;
  logic             keep, reading;

  tdc_edge_qual u_qual (
    .rise_i (rise_i),
    .fall_i (fall_i),
    .sel_i  (edge_sel_i),
    .hit_o  (hit_raw)
  );

  always_comb begin
    if (depth_i == '0)                  depth_eff = DEP_W'(1);
    else if (depth_i > DEP_W'(DEPTH))   depth_eff = DEP_W'(DEPTH);
    else                                depth_eff = depth_i;
  end

  assign acq     = (state_q == ST_ACQ);
  assign reading = (state_q == ST_READ);
  assign push    = acq && hit_raw;
  assign done_o  = reading && (count == '0);
  assign clear   = done_o;
  assign valid_o = reading && (count != '0) && keep;
  assign pop     = reading && (count != '0) && (!keep || ready_i);
  assign data_o  = {total_q, diff};
  assign hit_count_o = total_q;

  tdc_lifo #(.W(TS_W), .DEPTH(DEPTH)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .push_i  (push),
    .data_i  (ts_i),
    .limit_i (depth_eff),
    .pop_i   (pop),
    .top_o   (top),
    .count_o (count)
  );

  tdc_range_filter #(.TS_W(TS_W), .FS_SHIFT(FS_SHIFT)) u_filt (
    .stamp_i      (top),
    .common_i     (common_q),
    .stop_mode_i  (stop_mode_i),
    .full_scale_i (full_scale_i),
    .sparse_i     (sparse_i),
    .diff_o       (diff),
    .keep_o       (keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ACQ;
      common_q <= '0;
      total_q  <= '0;
    end else begin
      if (acq && common_i) common_q <= ts_i;
      if (clear)           total_q  <= '0;
      else if (push)       total_q  <= total_q + HC_W'(1); // counts even when full
      if (acq && read_start_i) state_q <= ST_READ;
      else if (done_o)         state_q <= ST_ACQ;
    end
  end
endmodule

// File: rtl/tdc_hit_store_chk.sv
module tdc_hit_store_chk
  import tdc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_o,
  input logic                 ready_i,
  input logic [HC_W+TS_W-1:0] data_o,
  input logic                 done_o,
  input logic [FS_W-1:0]      full_scale_i,
  input logic [TS_W-1:0]      sparse_i,
  input logic [HC_W-1:0]      hit_count_o
);
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R8
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_FS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> data_o[TS_W-1:0] <= {full_scale_i, {FS_SHIFT{1'b0}}}); // R5
  AST_SPARSE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> data_o[TS_W-1:0] > sparse_i); // R6
  AST_COUNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> hit_count_o == '0); // R7
endmodule

bind tdc_hit_store tdc_hit_store_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_o      (valid_o),
  .ready_i      (ready_i),
  .data_o       (data_o),
  .done_o       (done_o),
  .full_scale_i (full_scale_i),
  .sparse_i     (sparse_i),
  .hit_count_o  (hit_count_o)
);

// File: tb/tb_tdc_hit_store.sv
module tb_tdc_hit_store;
  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] ts_i = 0;
  logic        rise_i = 0, fall_i = 0, common_i = 0;
  logic [1:0]  edge_sel_i = 0;
  logic [4:0]  depth_i = 16;
  logic        stop_mode_i = 0;
  logic [11:0] full_scale_i = 0;
  logic [15:0] sparse_i = 0;
  logic        read_start_i = 0, ready_i = 0;
  logic        valid_o, done_o;
  logic [17:0] data_o;
  logic [1:0]  hit_count_o;

  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  tdc_hit_store dut (.*);

  typedef struct packed {
    logic        stop;
    logic [1:0]  sel;
    logic [4:0]  depth;
    logic [11:0] fs;
    logic [15:0] sparse;
    logic [4:0]  n;
    logic [15:0] base;
    logic [15:0] step;
    logic [15:0] cmn;
    logic [4:0]  exp_words;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b11, 5'd16, 12'd4095, 16'd0,   5'd3, 16'd100,   16'd50,  16'd1000, 5'd3}, // R1 R3 R4 stop
    '{1'b0, 2'b01, 5'd16, 12'd100,  16'd0,   5'd6, 16'd2000,  16'd500, 16'd1000, 5'd1}, // R1 R4 R5 start
    '{1'b1, 2'b10, 5'd2,  12'd4095, 16'd0,   5'd8, 16'd10,    16'd10,  16'd500,  5'd2}, // R2 R7
    '{1'b1, 2'b11, 5'd16, 12'd4095, 16'd300, 5'd4, 16'd100,   16'd100, 16'd500,  5'd1}, // R6
    '{1'b1, 2'b00, 5'd16, 12'd4095, 16'd0,   5'd4, 16'd100,   16'd100, 16'd500,  5'd0}, // R1 R9 none
    '{1'b0, 2'b11, 5'd1,  12'd1,    16'd0,   5'd2, 16'd1016,  16'd1,   16'd1000, 5'd1}, // R2 R5 edge
    '{1'b1, 2'b01, 5'd16, 12'd4095, 16'd0,   5'd1, 16'd65530, 16'd0,   16'd5,    5'd1}  // R4 wrap
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [17:0] exp_w [16];
  int          exp_n;

  task automatic model(input vec_t v);
    logic [15:0] st [16];
    int ns = 0, q = 0, lim;
    lim = (v.depth == 0) ? 1 : (v.depth > 16 ? 16 : int'(v.depth));
    for (int i = 0; i < int'(v.n); i++) begin
      bit qual = (i % 2 == 0) ? v.sel[0] : v.sel[1];
      if (qual) begin
        q++;
        if (ns < lim) begin st[ns] = v.base + 16'(i) * v.step; ns++; end
      end
    end
    exp_n = 0;
    for (int k = ns - 1; k >= 0; k--) begin
      logic [15:0] d = v.stop ? v.cmn - st[k] : st[k] - v.cmn;
      if (int'(d) <= int'(v.fs) * 16 && d > v.sparse) begin
        exp_w[exp_n] = {2'(q), d};
        exp_n++;
      end
    end
  endtask

  task automatic load(input vec_t v);
    @(negedge clk_i);
    stop_mode_i = v.stop; edge_sel_i = v.sel; depth_i = v.depth;
    full_scale_i = v.fs; sparse_i = v.sparse;
    for (int i = 0; i < int'(v.n); i++) begin
      ts_i = v.base + 16'(i) * v.step;
      rise_i = (i % 2 == 0); fall_i = (i % 2 == 1);
      @(negedge clk_i);
    end
    rise_i = 0; fall_i = 0;
    ts_i = v.cmn; common_i = 1;
    @(negedge clk_i);
    common_i = 0;
    read_start_i = 1;
    @(negedge clk_i);
    read_start_i = 0;
  endtask

  task automatic drain(input int exp_words);
    int got = 0, guard = 0;
    ready_i = 1;
    while (!done_o && guard < 100) begin
      if (valid_o) begin
        if (got < exp_n)
          chk(data_o == exp_w[got], "R3 R4 R7 word", int'(data_o), int'(exp_w[got]));
        got++;
      end
      @(negedge clk_i);
      guard++;
    end
    chk(done_o, "R9 done seen", int'(done_o), 1);
    chk(got == exp_n && got == exp_words, "R2 R5 R6 word count", got, exp_words);
    @(negedge clk_i);
    chk(!done_o, "R9 single pulse", int'(done_o), 0);
    chk(hit_count_o == 0, "R7 cleared", int'(hit_count_o), 0);
    ready_i = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!valid_o, "R10 valid", int'(valid_o), 0);
    chk(!done_o, "R10 done", int'(done_o), 0);
    chk(hit_count_o == 0, "R10 count", int'(hit_count_o), 0);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      model(VEC[i]);
      load(VEC[i]);
      drain(int'(VEC[i].exp_words));
    end

    // R8 R11: backpressure with hits during readout
    begin
      vec_t v = '{1'b1, 2'b11, 5'd16, 12'd4095, 16'd0, 5'd2, 16'd100, 16'd100, 16'd1000, 5'd2};
      model(v);
      load(v);
      for (int c = 0; c < 3; c++) begin
        rise_i = 1; ts_i = 16'd900;
        chk(valid_o && data_o == exp_w[0], "R8 hold", int'(data_o), int'(exp_w[0]));
        @(negedge clk_i);
      end
      rise_i = 0;
      chk(hit_count_o == 2, "R11 no count", int'(hit_count_o), 2);
      drain(2);
    end

    // R10: reset discards stored hits
    begin
      vec_t v = '{1'b1, 2'b11, 5'd16, 12'd4095, 16'd0, 5'd3, 16'd10, 16'd10, 16'd100, 5'd0};
      @(negedge clk_i);
      edge_sel_i = 2'b11; rise_i = 1; ts_i = 16'd10;
      @(negedge clk_i);
      rise_i = 0;
      rst_ni = 0;
      @(negedge clk_i);
      rst_ni = 1;
      chk(hit_count_o == 0, "R10 count after reset", int'(hit_count_o), 0);
      exp_n = 0;
      read_start_i = 1;
      @(negedge clk_i);
      read_start_i = 0;
      chk(done_o && !valid_o, "R10 R9 empty after reset", int'(done_o), 1);
      drain(int'(v.exp_words));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule